// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises a single interrupt output toward a processor. The host sees two byte-wide addresses. The command address takes the initialization start byte, the end-of-interrupt commands and the readback select. The data address takes the initialization words and, once initialization is done, the interrupt mask. When the processor pulses the acknowledge strobe, the block moves the winning request into service. One cycle later it returns a vector byte equal to a programmed base plus the input number.

Two copies can be chained. A copy set up as master knows which of its inputs have a slave behind them. When it acknowledges such an input, it drives a 3-bit cascade code during the acknowledge cycle and stays silent on the vector bus. The slave whose programmed identity matches that code answers instead. Each input can be edge- or level-sensitive. Auto end-of-interrupt mode and spurious-acknowledge reporting are supported.

Top module: `pic_top`

## Requirements
- R1: After reset the interrupt output, the mask, the in-service bits and the vector-valid flag are all zero, and command-address reads return the request register.
- R2: A command write with bit 4 set starts initialization. The next data writes are taken in order as the vector base, then the cascade word, then the mode word. The cascade word is skipped when bit 1 of the start byte is set (single mode), and the mode word is expected only when bit 0 of the start byte is set. Starting initialization clears the mask, the in-service bits and any latched edge requests, and selects the request register for readback.
- R3: For a genuine acknowledge of input n, vecValid is high in the cycle after the acknowledge cycle, and vecOut then equals base+n.
- R4: Outside initialization, data-address writes load the mask and data-address reads return it. A set mask bit keeps that input from raising intOut, but the input still shows in the request register.
- R5: Command byte 0x0B makes later command-address reads return the in-service register. Command byte 0x0A makes them return the request register.
- R6: Input 0 has the highest priority and input 7 the lowest. intOut is high only when the best unmasked request outranks every in-service bit.
- R7: An acknowledge sets the winner's in-service bit and clears its latched edge request.
- R8: Command 0x60+n clears in-service bit n. Command 0x20 clears the highest-priority in-service bit. An interrupt routed through a slave stays in service on the master until the master itself receives its own end-of-interrupt.
- R9: When bit 1 of the mode word is set (auto end-of-interrupt), an acknowledge sets no in-service bit.
- R10: An acknowledge with no qualifying request, including one whose request dropped before the acknowledge or one where input 7 is masked, returns base+7 and changes no in-service bit.
- R11: When levelMask bit n is 0, input n latches on a rising edge and holds after the line falls. When levelMask bit n is 1, its request bit follows the line.
- R12: Mode-word bit 2 set makes the block a master. When the winner at acknowledge has its cascade-word bit set, casOutEn is 1 and casOut is n during the acknowledge cycle, and the master returns no vector.
- R13: Mode-word bit 2 clear makes the block a slave. It acts on intAck only when casInEn is 1 and casIn equals bits 2:0 of its cascade word, and it ignores the strobe otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| addrSel | input | 1 | 0 selects the command address, 1 selects the data address |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte (combinational) |
| irqLines | input | 8 | Interrupt request lines |
| levelMask | input | 8 | Per-input level-sensitive enable |
| intAck | input | 1 | One-cycle acknowledge strobe |
| intOut | output | 1 | Interrupt request to the processor |
| casInEn | input | 1 | Cascade code valid from the master |
| casIn | input | 3 | Cascade code from the master |
| casOutEn | output | 1 | This master is handing the acknowledge to a slave |
| casOut | output | 3 | Cascade code driven by a master |
| vecValid | output | 1 | Vector byte valid |
| vecOut | output | 8 | Vector byte |

## Verification
A request line driven at a falling edge lands in the request register at the next rising edge, so intOut and the readback are sampled one full cycle later. A slave's request needs one more cycle to reach the master. The cascade code is combinational and is sampled in the acknowledge cycle itself. The vector is registered, so it is sampled at the falling edge that follows the acknowledge cycle. Readback paths are combinational from registers, so every read is taken a moment after the address settles, at a falling edge with no write pending.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_LINES = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CAS_W = $clog2(PIC_LINES);

  // mode word bit positions
  localparam int unsigned MODE_AEOI_BIT = 1;
  localparam int unsigned MODE_MASTER_BIT = 2;
  // start byte bit positions
  localparam int unsigned START_BIT = 4;
  localparam int unsigned START_SINGLE_BIT = 1;
  localparam int unsigned START_MODE_BIT = 0;
  localparam int unsigned CMD_SEL_BIT = 3;

  typedef logic [PIC_LINES-1:0] lineVec_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_CAS,
    INIT_MODE
  } initState_t;

  typedef struct packed {
    logic initStart;
    logic singleMode;
    logic loadBase;
    logic loadCas;
    logic loadMode;
    logic loadImr;
    logic eoiSpec;
    logic eoiAny;
    logic [CAS_W-1:0] eoiNum;
    logic selIsr;
    logic selIrr;
  } ctrlStrobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        addrSel,
  input  byte_t       wrData,
  output ctrlStrobe_t strobe
);
  initState_t state, stateNext;
  logic needCas, needMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= INIT_IDLE;
      needCas <= 1'b0;
      needMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.initStart) begin
        needCas <= !wrData[START_SINGLE_BIT];
        needMode <= wrData[START_MODE_BIT];
      end
    end
  end

  always_comb begin
    strobe = '0;
    stateNext = state;
    if (wrEn && !addrSel) begin
      if (wrData[START_BIT]) begin
        strobe.initStart = 1'b1;
        strobe.singleMode = wrData[START_SINGLE_BIT];
        stateNext = INIT_BASE;
      end else if (state == INIT_IDLE) begin
        if (wrData[CMD_SEL_BIT]) begin
          if (wrData[1:0] == 2'b11) strobe.selIsr = 1'b1;
          else if (wrData[1:0] == 2'b10) strobe.selIrr = 1'b1;
        end else begin
          case (wrData[7:5])
            3'b011: begin
              strobe.eoiSpec = 1'b1;
              strobe.eoiNum = wrData[CAS_W-1:0];
            end
            3'b001: strobe.eoiAny = 1'b1;
            default: ;
          endcase
        end
      end
    end else if (wrEn && addrSel) begin
      case (state)
        INIT_IDLE: strobe.loadImr = 1'b1;
        INIT_BASE: begin
          strobe.loadBase = 1'b1;
          if (needCas) stateNext = INIT_CAS;
          else if (needMode) stateNext = INIT_MODE;
          else stateNext = INIT_IDLE;
        end
        INIT_CAS: begin
          strobe.loadCas = 1'b1;
          stateNext = needMode ? INIT_MODE : INIT_IDLE;
        end
        default: begin
          strobe.loadMode = 1'b1;
          stateNext = INIT_IDLE;
        end
      endcase
    end
  end

  // R2
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadBase, strobe.loadCas, strobe.loadMode, strobe.loadImr}));
  // R2
  mode_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == INIT_MODE) |-> needMode);
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  byte_t            wrData,
  input  lineVec_t         irqLines,
  input  lineVec_t         levelMask,
  input  logic             intAck,
  input  logic             casInEn,
  input  logic [CAS_W-1:0] casIn,
  output byte_t            cmdRead,
  output byte_t            imrRead,
  output logic             intOut,
  output logic             casOutEn,
  output logic [CAS_W-1:0] casOut,
  output logic             vecValid,
  output byte_t            vecOut
);
  lineVec_t irr, isr, imr, prevLine, casCfg;
  byte_t base;
  logic aeoi, isMaster, singleMode, readIsr;

  lineVec_t eligible, rise, winOneHot, ackSet, ackClr, eoiClr;
  logic [CAS_W-1:0] winIdx, isrTop;
  logic winValid, isrAny, reqWin, selected, cascadeHit, accept;

  always_comb begin
    eligible = irr & ~imr;
    winIdx = '0;
    winValid = 1'b0;
    isrTop = '0;
    isrAny = 1'b0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winIdx = CAS_W'(i);
        winValid = 1'b1;
      end
      if (isr[i]) begin
        isrTop = CAS_W'(i);
        isrAny = 1'b1;
      end
    end
  end

  assign reqWin = winValid && (!isrAny || (winIdx < isrTop));
  assign winOneHot = lineVec_t'(1) << winIdx;
  assign selected = isMaster ? intAck : (intAck && casInEn && (casIn == casCfg[CAS_W-1:0]));
  assign cascadeHit = isMaster && !singleMode && reqWin && casCfg[winIdx];
  assign accept = selected && reqWin;
  assign ackClr = accept ? winOneHot : '0;
  assign ackSet = (accept && !aeoi) ? winOneHot : '0;
  assign rise = irqLines & ~prevLine;

  always_comb begin
    eoiClr = '0;
    if (strobe.eoiSpec) eoiClr = lineVec_t'(1) << strobe.eoiNum;
    else if (strobe.eoiAny && isrAny) eoiClr = lineVec_t'(1) << isrTop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      imr <= '0;
      prevLine <= '0;
      casCfg <= '0;
      base <= '0;
      aeoi <= 1'b0;
      isMaster <= 1'b1;
      singleMode <= 1'b0;
      readIsr <= 1'b0;
      vecValid <= 1'b0;
      vecOut <= '0;
    end else begin
      prevLine <= irqLines;
      for (int i = 0; i < PIC_LINES; i++) begin
        if (levelMask[i]) irr[i] <= irqLines[i];
        else irr[i] <= (irr[i] & ~ackClr[i] & ~strobe.initStart) | rise[i];
      end
      if (strobe.initStart) begin
        isr <= '0;
        imr <= '0;
        casCfg <= '0;
        aeoi <= 1'b0;
        isMaster <= 1'b1;
        singleMode <= strobe.singleMode;
        readIsr <= 1'b0;
      end else begin
        isr <= (isr & ~eoiClr) | ackSet;
        if (strobe.loadImr) imr <= wrData;
        if (strobe.loadCas) casCfg <= wrData;
        if (strobe.loadMode) begin
          aeoi <= wrData[MODE_AEOI_BIT];
          isMaster <= wrData[MODE_MASTER_BIT];
        end
        if (strobe.selIsr) readIsr <= 1'b1;
        else if (strobe.selIrr) readIsr <= 1'b0;
      end
      if (strobe.loadBase) base <= wrData;
      vecValid <= selected && !cascadeHit;
      vecOut <= base + (accept ? byte_t'(winIdx) : byte_t'(PIC_LINES - 1));
    end
  end

  assign intOut = reqWin;
  assign casOutEn = intAck && cascadeHit;
  assign casOut = winIdx;
  assign cmdRead = readIsr ? isr : irr;
  assign imrRead = imr;

  // R3
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck));
  // R7
  isr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !aeoi && !strobe.initStart) |=> ((isr & $past(winOneHot)) != '0));
  // R9
  aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aeoi && $past(aeoi) && !$past(strobe.initStart)) |-> ((isr & ~$past(isr)) == '0));
  // R12
  cas_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    casOutEn |-> (intAck && isMaster));
  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irr & ~imr) != '0));
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             addrSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [7:0]       irqLines,
  input  logic [7:0]       levelMask,
  input  logic             intAck,
  output logic             intOut,
  input  logic             casInEn,
  input  logic [2:0]       casIn,
  output logic             casOutEn,
  output logic [2:0]       casOut,
  output logic             vecValid,
  output logic [7:0]       vecOut
);
  ctrlStrobe_t strobe;
  byte_t cmdRead, imrRead;

  pic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrSel(addrSel),
    .wrData(wrData), .strobe(strobe)
  );

  pic_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .irqLines(irqLines), .levelMask(levelMask), .intAck(intAck),
    .casInEn(casInEn), .casIn(casIn), .cmdRead(cmdRead), .imrRead(imrRead),
    .intOut(intOut), .casOutEn(casOutEn), .casOut(casOut),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  assign rdData = addrSel ? imrRead : cmdRead;
endmodule

// File: tb/sim_pic_top.sv
`timescale 1ns/100ps
module sim_pic_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrM = 1'b0, wrS = 1'b0, addr = 1'b0, intAck = 1'b0;
  logic [7:0] wdata = '0, benchM = '0, linesS = '0, lvlM = 8'hFF;
  logic [7:0] rdM, rdS, vecM, vecS, lineM;
  logic intM, intS, casEnM, casEnS, vvM, vvS;
  logic [2:0] casM, casS;
  int passCnt = 0, failCnt = 0;
  logic ackCasEn, ackDone;
  logic [2:0] ackCas;

  always #2.5 clk = ~clk;

  assign lineM = {benchM[7:3], intS, benchM[1:0]};

  pic_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrM), .addrSel(addr), .wrData(wdata), .rdData(rdM),
    .irqLines(lineM), .levelMask(lvlM), .intAck(intAck), .intOut(intM),
    .casInEn(1'b0), .casIn(3'd0), .casOutEn(casEnM), .casOut(casM),
    .vecValid(vvM), .vecOut(vecM)
  );
  pic_top u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrS), .addrSel(addr), .wrData(wdata), .rdData(rdS),
    .irqLines(linesS), .levelMask(8'hFF), .intAck(intAck), .intOut(intS),
    .casInEn(casEnM), .casIn(casM), .casOutEn(casEnS), .casOut(casS),
    .vecValid(vvS), .vecOut(vecS)
  );

  typedef struct packed {
    logic [7:0] imr;
    logic [7:0] lines;
    logic expInt;
    logic [7:0] expVec;
  } row_t;
  localparam row_t TBL [0:7] = '{
    '{8'h00, 8'h01, 1'b1, 8'h20},
    '{8'h00, 8'h88, 1'b1, 8'h23},
    '{8'h08, 8'h88, 1'b1, 8'h27},
    '{8'h00, 8'h60, 1'b1, 8'h25},
    '{8'h60, 8'h60, 1'b0, 8'h27},
    '{8'hFB, 8'hF9, 1'b0, 8'h27},
    '{8'h01, 8'h03, 1'b1, 8'h21},
    '{8'h00, 8'h80, 1'b1, 8'h27}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    if (act === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit toS, input bit a, input logic [7:0] d);
    addr = a; wdata = d;
    if (toS) wrS = 1'b1; else wrM = 1'b1;
    @(negedge clk);
    wrM = 1'b0; wrS = 1'b0;
  endtask

  task automatic rd(input bit fromS, input bit a, output logic [7:0] d);
    addr = a;
    #1;
    d = fromS ? rdS : rdM;
  endtask

  task automatic ack();
    intAck = 1'b1;
    #1;
    ackCasEn = casEnM; ackCas = casM;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic init_master(input logic [7:0] mode);
    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, mode);
  endtask

  logic [7:0] r;

  initial begin
    ackDone = 1'b0;
    wait_n(4);
    rstN = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 intOut", {7'd0, intM}, 8'h00);
    chk("R1 vecValid", {7'd0, vvM}, 8'h00);
    rd(0, 1, r); chk("R1 mask", r, 8'h00);
    benchM = 8'h10; wait_n(2);
    rd(0, 0, r); chk("R1 readback is request register", r, 8'h10);
    benchM = 8'h00; wait_n(2);

    init_master(8'h04);
    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h00);

    // R2/R4 mask loads, then initialization clears it
    wr(0, 1, 8'h5A); rd(0, 1, r); chk("R4 mask readback", r, 8'h5A);
    init_master(8'h04); rd(0, 1, r); chk("R2 init clears mask", r, 8'h00);

    // table walk: R3 R4 R6 R10
    wr(0, 0, 8'h0B);
    for (int k = 0; k < 8; k++) begin
      wr(0, 1, TBL[k].imr);
      benchM = TBL[k].lines;
      wait_n(2);
      chk("R6 intOut", {7'd0, intM}, {7'd0, TBL[k].expInt});
      ack();
      chk("R3 vecValid", {7'd0, vvM}, 8'h01);
      chk("R3/R10 vector", vecM, TBL[k].expVec);
      rd(0, 0, r);
      chk("R7/R10 in-service", r, TBL[k].expInt ? (8'h01 << TBL[k].expVec[2:0]) : 8'h00);
      benchM = 8'h00;
      if (TBL[k].expInt) wr(0, 0, 8'h60 + {5'd0, TBL[k].expVec[2:0]});
      wait_n(1);
    end
    wr(0, 1, 8'h00);

    // R5 readback select
    benchM = 8'h41; wait_n(2);
    wr(0, 0, 8'h0A); rd(0, 0, r); chk("R5 request readback", r, 8'h41);
    ack();
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R5 in-service readback", r, 8'h01);
    wr(0, 0, 8'h0A); rd(0, 0, r); chk("R5 back to request", r, 8'h41);
    benchM = 8'h00; wr(0, 0, 8'h60);

    // R6 nesting, R8 EOI kinds
    benchM = 8'h08; wait_n(2); ack();
    benchM = 8'h28; wait_n(2);
    chk("R6 lower priority held off", {7'd0, intM}, 8'h00);
    benchM = 8'h2A; wait_n(2);
    chk("R6 higher priority nests", {7'd0, intM}, 8'h01);
    ack(); chk("R3 nested vector", vecM, 8'h21);
    benchM = 8'h00;
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R7 nested in-service", r, 8'h0A);
    wr(0, 0, 8'h20); rd(0, 0, r); chk("R8 non-specific EOI", r, 8'h08);
    wr(0, 0, 8'h63); rd(0, 0, r); chk("R8 specific EOI", r, 8'h00);

    // R2 re-init clears in-service
    benchM = 8'h10; wait_n(2); ack(); benchM = 8'h00;
    init_master(8'h04);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R2 init clears in-service", r, 8'h00);

    // R9 auto EOI
    init_master(8'h06);
    benchM = 8'h10; wait_n(2); ack();
    chk("R9 vector", vecM, 8'h24);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R9 no in-service bit", r, 8'h00);
    benchM = 8'h00;
    init_master(8'h04);

    // R11 edge and level
    lvlM = 8'hDF;
    benchM = 8'h60; wait_n(1); benchM = 8'h00; wait_n(2);
    rd(0, 0, r); chk("R11 edge held, level follows", r, 8'h20);
    chk("R11 edge raises intOut", {7'd0, intM}, 8'h01);
    ack(); chk("R11 edge vector", vecM, 8'h25);
    rd(0, 0, r); chk("R7 edge request cleared", r, 8'h00);
    wr(0, 0, 8'h65);
    lvlM = 8'hFF;

    // R10 request vanishes before acknowledge
    benchM = 8'h10; wait_n(2);
    benchM = 8'h00; wait_n(1); ack();
    chk("R10 vanished request vector", vecM, 8'h27);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R10 no in-service bit", r, 8'h00);

    // R2 single mode: second data word is the mode word
    wr(0, 0, 8'h13); wr(0, 1, 8'h40); wr(0, 1, 8'h06);
    benchM = 8'h40; wait_n(2); ack();
    chk("R2 single-mode vector", vecM, 8'h46);
    wr(0, 0, 8'h0B); rd(0, 0, r); chk("R2 single-mode took mode word", r, 8'h00);
    benchM = 8'h00;
    init_master(8'h04);

    // R12 R13 R8 cascade
    linesS = 8'h08; wait_n(3);
    chk("R12 master sees slave", {7'd0, intM}, 8'h01);
    ack();
    chk("R12 cascade enable", {7'd0, ackCasEn}, 8'h01);
    chk("R12 cascade code", {5'd0, ackCas}, 8'h02);
    chk("R12 master silent", {7'd0, vvM}, 8'h00);
    chk("R13 slave vector valid", {7'd0, vvS}, 8'h01);
    chk("R13 slave vector", vecS, 8'h2B);
    linesS = 8'h00;
    wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);
    rd(1, 0, r); chk("R13 slave in-service", r, 8'h08);
    wr(1, 0, 8'h63);
    rd(1, 0, r); chk("R8 slave retired", r, 8'h00);
    rd(0, 0, r); chk("R8 master still in service", r, 8'h04);
    wr(0, 0, 8'h62);
    rd(0, 0, r); chk("R8 master retired", r, 8'h00);

    // R13 slave ignores an acknowledge not addressed to it
    wr(0, 1, 8'h04);
    linesS = 8'h01; benchM = 8'h02; wait_n(3);
    ack();
    chk("R12 no cascade for plain input", {7'd0, ackCasEn}, 8'h00);
    chk("R3 master vector", vecM, 8'h21);
    chk("R13 slave silent", {7'd0, vvS}, 8'h00);
    rd(1, 0, r); chk("R13 slave in-service untouched", r, 8'h00);
    linesS = 8'h00; benchM = 8'h00;
    wr(0, 0, 8'h61);

    ackDone = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ackDone) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end
endmodule